// File: doc/BRIEF.md
# Sequential Shift-Subtract Integer Divider

This block divides a double-width dividend, supplied as a high half and a low half, by a single-width divisor. It produces a quotient, a remainder, or a divide fault. The operand width N is picked per operation from four sizes: one eighth, one quarter, one half or all of `DATA_W`. With the default of 64 these are 8, 16, 32 and 64 bits. Only the low N bits of each operand input take part. Unsigned or two's-complement signed division is chosen by a flag.

A one-cycle `start` pulse captures the operands. A zero divisor, or a magnitude quotient too wide for N bits, is recognised at capture and finishes at once. Otherwise a radix-2 loop produces one quotient bit per cycle. For signed work the operands are first reduced to magnitudes. After the loop the quotient is range-checked against the signed limits and the signs are restored. When the high half is zero, the loop reduces to dividing the low half alone.

Top module: `seq_divider`

## Requirements
- R1: A divisor whose low N bits are zero raises `fault` with `quotient` and `remainder` both zero, and `done` is high in the cycle after the cycle of the accepted `start`.
- R2: In unsigned mode, a dividend high half greater than or equal to the divisor raises `fault` with zero results, with the same one-cycle latency as R1. In signed mode the same early fault and latency apply when the magnitude quotient would not fit in N bits.
- R3: In unsigned mode without a fault, `quotient` = floor(dividend / divisor) and `remainder` = dividend mod divisor, zero-extended to `DATA_W`. `done` is high N+1 cycles after the accepted `start`. `sizeSel` 0, 1, 2 and 3 give N = DATA_W/8, /4, /2 and DATA_W.
- R4: With a zero high half and a nonzero divisor, an unsigned result equals low half / divisor and low half mod divisor, and never faults.
- R5: In signed mode the quotient is truncated toward zero. The remainder carries the dividend's sign. Both are returned as N-bit two's complement values, zero-extended to `DATA_W`.
- R6: In signed mode with operand signs that differ, a magnitude quotient of exactly 2^(N-1) is a valid result and anything larger faults. With matching signs, 2^(N-1) or more faults. Such range faults zero both results and complete N+1 cycles after `start`.
- R7: `packedByte` holds the remainder's low byte in bits 15:8 and the quotient's low byte in bits 7:0. In 8-bit mode it is the complete packed result.
- R8: `done` is high for exactly one cycle per operation. `quotient`, `remainder`, `fault` and `packedByte` change only in the cycle where `done` rises, and hold their values otherwise.
- R9: A `start` pulse that arrives while an operation is in progress is ignored. The running operation completes with its original operands and timing.
- R10: After reset, `done`, `fault`, `quotient`, `remainder` and `packedByte` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a division |
| sizeSel | input | 2 | Operand width select (0: DATA_W/8, 1: /4, 2: /2, 3: DATA_W) |
| isSigned | input | 1 | 1 selects two's-complement division |
| dvdHi | input | DATA_W | Upper half of the dividend (low N bits used) |
| dvdLo | input | DATA_W | Lower half of the dividend (low N bits used) |
| divisor | input | DATA_W | Divisor (low N bits used) |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | DATA_W | Quotient, N bits zero-extended |
| remainder | output | DATA_W | Remainder, N bits zero-extended |
| fault | output | 1 | Divide fault of the last operation |
| packedByte | output | 16 | {remainder[7:0], quotient[7:0]} |

## Verification
A corrupted partial remainder or quotient shift register goes unseen until the operation ends. It then shows as a wrong quotient or remainder on the `done` cycle, N+1 cycles after `start`. A wrong iteration count or a wrong state transition shows up sooner. The bench predicts the exact `done` cycle, so the pulse arrives early, arrives late or repeats, and the mismatch is reported on that very clock. A bad early-fault decision moves `done` from N+1 cycles to one cycle, or the reverse, so the latency alone exposes it before any data is compared.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // capture operands and magnitudes
    logic step;    // one radix-2 iteration
    logic finish;  // range check, sign restore, register outputs
  } divStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } divState_t;

endpackage

// File: rtl/seqdiv_ctrl.sv
module seqdiv_ctrl
  import seqdiv_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] sizeSel,
  input  logic       earlyFault,
  input  logic       zeroDiv,
  output divStrobe_t strb,
  output logic       done
);

  localparam int WID_W = $clog2(DATA_W) + 1;
  localparam int CNT_W = $clog2(DATA_W);

  divState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [WID_W-1:0] wIn;

  always_comb begin
    wIn         = WID_W'(DATA_W >> (2'd3 - sizeSel));
    strb.load   = (state == ST_IDLE) && start;
    strb.step   = (state == ST_RUN);
    strb.finish = (state == ST_FIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= (state == ST_FIN);
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= earlyFault ? ST_FIN : ST_RUN;
            cnt   <= CNT_W'(wIn - 1'b1);
          end
        end
        ST_RUN: begin
          if (cnt == '0) state <= ST_FIN;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && cnt != '0) |=> (state == ST_RUN && cnt == $past(cnt) - 1'b1));

  // R1
  zero_div_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.load && zeroDiv) |=> (state == ST_FIN));

endmodule

// File: rtl/seqdiv_datapath.sv
module seqdiv_datapath
  import seqdiv_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  divStrobe_t        strb,
  input  logic [1:0]        sizeSel,
  input  logic              isSigned,
  input  logic [DATA_W-1:0] dvdHi,
  input  logic [DATA_W-1:0] dvdLo,
  input  logic [DATA_W-1:0] divisor,
  output logic              earlyFault,
  output logic              zeroDiv,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder,
  output logic              fault,
  output logic [15:0]       packedByte
);

  localparam int DW2   = 2 * DATA_W;
  localparam int WID_W = $clog2(DATA_W) + 1;

  function automatic logic topBit(input logic [DATA_W-1:0] v, input logic [WID_W-1:0] w);
    logic [DATA_W-1:0] s;
    s = v >> (w - 1'b1);
    return s[0];
  endfunction

  // operand preparation (combinational, used on load)
  logic [WID_W-1:0]  wIn;
  logic [DATA_W-1:0] mIn, hiM, loM, dvM, magHi, magLo, magDiv;
  logic [DW2-1:0]    m2In, dvdRaw, dvdMag;
  logic              sa, sb;

  always_comb begin
    wIn        = WID_W'(DATA_W >> (2'd3 - sizeSel));
    mIn        = {DATA_W{1'b1}} >> (DATA_W - int'(wIn));
    m2In       = {DW2{1'b1}} >> (DW2 - 2 * int'(wIn));
    hiM        = dvdHi & mIn;
    loM        = dvdLo & mIn;
    dvM        = divisor & mIn;
    sa         = isSigned && topBit(hiM, wIn);
    sb         = isSigned && topBit(dvM, wIn);
    dvdRaw     = ({{DATA_W{1'b0}}, hiM} << wIn) | {{DATA_W{1'b0}}, loM};
    dvdMag     = sa ? ((~dvdRaw + 1'b1) & m2In) : dvdRaw;
    magHi      = DATA_W'(dvdMag >> wIn);
    magLo      = dvdMag[DATA_W-1:0] & mIn;
    magDiv     = sb ? ((~dvM + 1'b1) & mIn) : dvM;
    zeroDiv    = (dvM == '0);
    earlyFault = zeroDiv || (magHi >= magDiv);
  end

  // iteration state
  logic [DATA_W-1:0] remReg, loReg, divReg, mReg;
  logic [WID_W-1:0]  wReg;
  logic              sgnReg, negDvd, negDiv, earlyReg;

  logic              topLo, outBit, take;
  logic [DATA_W:0]   shifted, shiftedHi;
  logic [DATA_W-1:0] remN, remNext, loNext;

  always_comb begin
    topLo     = topBit(loReg, wReg);
    shifted   = {remReg, topLo};
    shiftedHi = shifted >> wReg;
    outBit    = shiftedHi[0];
    remN      = shifted[DATA_W-1:0] & mReg;
    take      = outBit || (remN >= divReg);
    remNext   = take ? ((remN - divReg) & mReg) : remN;
    loNext    = {loReg[DATA_W-2:0], take} & mReg;
  end

  // post-processing
  logic [DATA_W-1:0] halfVal, negQ, negR, qFin, rFin;
  logic              rangeBad, fFin;

  always_comb begin
    halfVal  = {{(DATA_W-1){1'b0}}, 1'b1} << (wReg - 1'b1);
    negQ     = (~loReg + 1'b1) & mReg;
    negR     = (~remReg + 1'b1) & mReg;
    rangeBad = 1'b0;
    qFin     = loReg;
    rFin     = remReg;
    if (sgnReg) begin
      if (negDvd ^ negDiv) begin
        rangeBad = (loReg > halfVal);
        qFin     = negQ;
      end else begin
        rangeBad = (loReg >= halfVal);
      end
      if (negDvd) rFin = negR;
    end
    fFin = earlyReg || rangeBad;
    if (fFin) begin
      qFin = '0;
      rFin = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remReg     <= '0;
      loReg      <= '0;
      divReg     <= '0;
      mReg       <= '0;
      wReg       <= '0;
      sgnReg     <= 1'b0;
      negDvd     <= 1'b0;
      negDiv     <= 1'b0;
      earlyReg   <= 1'b0;
      quotient   <= '0;
      remainder  <= '0;
      fault      <= 1'b0;
      packedByte <= '0;
    end else begin
      if (strb.load) begin
        remReg   <= magHi;
        loReg    <= magLo;
        divReg   <= magDiv;
        mReg     <= mIn;
        wReg     <= wIn;
        sgnReg   <= isSigned;
        negDvd   <= sa;
        negDiv   <= sb;
        earlyReg <= earlyFault;
      end
      if (strb.step) begin
        remReg <= remNext;
        loReg  <= loNext;
      end
      if (strb.finish) begin
        quotient   <= qFin;
        remainder  <= rFin;
        fault      <= fFin;
        packedByte <= {rFin[7:0], qFin[7:0]};
      end
    end
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.finish |=> ($stable(quotient) && $stable(remainder) && $stable(fault)));

  // R3
  partial_rem_chk: assert property (@(posedge clk) disable iff (rst)
    strb.step |=> (remReg < divReg));

  // R2
  early_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.load && earlyFault) |=> ##1 (fault && quotient == '0));

endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import seqdiv_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        sizeSel,
  input  logic              isSigned,
  input  logic [DATA_W-1:0] dvdHi,
  input  logic [DATA_W-1:0] dvdLo,
  input  logic [DATA_W-1:0] divisor,
  output logic              done,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder,
  output logic              fault,
  output logic [15:0]       packedByte
);

  divStrobe_t strb;
  logic       earlyFault;
  logic       zeroDiv;

  seqdiv_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .sizeSel   (sizeSel),
    .earlyFault(earlyFault),
    .zeroDiv   (zeroDiv),
    .strb      (strb),
    .done      (done)
  );

  seqdiv_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .sizeSel   (sizeSel),
    .isSigned  (isSigned),
    .dvdHi     (dvdHi),
    .dvdLo     (dvdLo),
    .divisor   (divisor),
    .earlyFault(earlyFault),
    .zeroDiv   (zeroDiv),
    .quotient  (quotient),
    .remainder (remainder),
    .fault     (fault),
    .packedByte(packedByte)
  );

endmodule

// File: tb/seq_divider_bench.sv
module seq_divider_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  sizeSel = 2'd0;
  logic        isSigned = 1'b0;
  logic [63:0] dvdHi = '0, dvdLo = '0, divisor = '0;
  logic        done, fault;
  logic [63:0] quotient, remainder;
  logic [15:0] packedByte;

  int    vecCount = 0;
  int    errCount = 0;
  string curReq = "R10";
  bit    seenEdge = 1'b0;

  // reference model state
  int          cdM = 0;
  logic        expDone = 1'b0, expF = 1'b0, pendF = 1'b0;
  logic [63:0] expQ = '0, expR = '0, pendQ = '0, pendR = '0;
  int          pendLat = 0;

  always #10 clk = ~clk;

  seq_divider u_seq_divider (
    .clk(clk), .rst(rst), .start(start), .sizeSel(sizeSel), .isSigned(isSigned),
    .dvdHi(dvdHi), .dvdLo(dvdLo), .divisor(divisor), .done(done),
    .quotient(quotient), .remainder(remainder), .fault(fault), .packedByte(packedByte)
  );

  task automatic modelCompute(input logic [1:0] sz, input logic sg,
                              input logic [63:0] hi, input logic [63:0] lo, input logic [63:0] dv);
    int n;
    logic [63:0] m;
    logic [127:0] raw;
    logic signed [131:0] num, den, q, r, aNum, aDen, qa, lim;
    n   = 8 << sz;
    m   = {64{1'b1}} >> (64 - n);
    raw = ({64'b0, hi & m} << n) | {64'b0, lo & m};
    num = $signed({4'b0, raw});
    if (sg && raw[2*n-1]) num = num - (132'sd1 <<< (2*n));
    den = $signed({68'b0, dv & m});
    if (sg && dv[n-1]) den = den - (132'sd1 <<< n);
    pendQ = '0; pendR = '0;
    if (den == 0) begin
      pendF = 1'b1; pendLat = 1;
    end else begin
      aNum = (num < 0) ? -num : num;
      aDen = (den < 0) ? -den : den;
      qa   = aNum / aDen;
      if (qa >= (132'sd1 <<< n)) begin
        pendF = 1'b1; pendLat = 1;
      end else begin
        pendLat = n + 1;
        q = num / den;
        r = num % den;
        lim = 132'sd1 <<< (n - 1);
        pendF = sg && ((q > lim - 1) || (q < -lim));
        if (!pendF) begin
          pendQ = q[63:0] & m;
          pendR = r[63:0] & m;
        end
      end
    end
  endtask

  always @(posedge clk) begin
    seenEdge <= 1'b1;
    if (rst) begin
      cdM = 0; expDone = 1'b0; expF = 1'b0; expQ = '0; expR = '0;
    end else begin
      expDone = 1'b0;
      if (cdM > 0) begin
        cdM--;
        if (cdM == 0) begin
          expDone = 1'b1; expQ = pendQ; expR = pendR; expF = pendF;
        end
      end else if (start) begin
        modelCompute(sizeSel, isSigned, dvdHi, dvdLo, divisor);
        cdM = pendLat;
      end
    end
  end

  task automatic cmp(string what, logic [63:0] act, logic [63:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s %s: actual %h expected %h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (seenEdge) begin
      cmp("done", {63'b0, done}, {63'b0, expDone});
      cmp("fault", {63'b0, fault}, {63'b0, expF});
      cmp("quotient", quotient, expQ);
      cmp("remainder", remainder, expR);
      // R7 packed byte pair
      cmp("packedByte", {48'b0, packedByte}, {48'b0, expR[7:0], expQ[7:0]});
    end
  end

  task automatic runOp(string tag, logic [1:0] sz, logic sg,
                       logic [63:0] hi, logic [63:0] lo, logic [63:0] dv);
    @(negedge clk);
    curReq = tag;
    sizeSel = sz; isSigned = sg; dvdHi = hi; dvdLo = lo; divisor = dv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (cdM != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    runOp("R3", 2'd0, 1'b0, 64'h00, 64'h64, 64'h07);            // 100/7
    runOp("R7", 2'd0, 1'b0, 64'h12, 64'h34, 64'h9A);            // packed 8-bit
    runOp("R2", 2'd0, 1'b0, 64'h10, 64'h00, 64'h10);            // hi == divisor
    runOp("R1", 2'd0, 1'b0, 64'h01, 64'h02, 64'h100);           // low byte zero
    runOp("R5", 2'd0, 1'b1, 64'hFF, 64'h9C, 64'h07);            // -100/7
    runOp("R6", 2'd0, 1'b1, 64'hFF, 64'h80, 64'h01);            // -128/1 valid
    runOp("R6", 2'd0, 1'b1, 64'hFF, 64'h80, 64'hFF);            // -128/-1 faults late
    runOp("R3", 2'd1, 1'b0, 64'h0001, 64'h0000, 64'h0003);      // 65536/3
    runOp("R1", 2'd1, 1'b1, 64'h1234, 64'h5678, 64'hABCD_0000);
    runOp("R5", 2'd2, 1'b1, 64'hFFFF_FFFF, 64'hFFFF_FC18, 64'hFFFF_FFF9);
    runOp("R3", 2'd3, 1'b0, 64'h5, 64'h0123_4567_89AB_CDEF, 64'h1_0000_0001);
    runOp("R4", 2'd3, 1'b0, 64'h0, 64'd1000, 64'd7);
    runOp("R4", 2'd3, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    runOp("R2", 2'd3, 1'b0, 64'h7, 64'h0, 64'h7);
    runOp("R2", 2'd2, 1'b1, 64'h4000_0000, 64'h0, 64'h2);       // signed magnitude too wide
    runOp("R6", 2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    runOp("R6", 2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'h1);

    // R9: second start while busy must be ignored
    @(negedge clk);
    curReq = "R9";
    sizeSel = 2'd1; isSigned = 1'b0; dvdHi = 64'h0002; dvdLo = 64'h1111; divisor = 64'h0101;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    dvdHi = 64'h0; dvdLo = 64'h5; divisor = 64'h0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (cdM != 0) @(negedge clk);
    @(negedge clk);

    // R8: back-to-back operations, outputs held between them
    for (int i = 0; i < 48; i++) begin
      logic [1:0]  sz;
      logic        sg;
      logic [63:0] a, b, c;
      sz = 2'($urandom_range(0, 3));
      sg = 1'($urandom_range(0, 1));
      a  = {$urandom, $urandom};
      b  = {$urandom, $urandom};
      c  = {$urandom, $urandom} | 64'h1;
      if (i % 2 == 0) a = a % c;
      if (i % 7 == 0) a = (sg && a[0]) ? '1 : '0;
      runOp((i % 3 == 0) ? "R8" : (sg ? "R5" : "R3"), sz, sg, a, b, c);
      repeat (i % 3) @(negedge clk);
    end

    finishRun();
  end

endmodule